// File: doc/BRIEF.md
# Rectangle Fill and Copy Blitter

This block is a small 2D drawing engine for a 16-bit-per-pixel frame memory. A host feeds it 32-bit command words. Most words load one internal parameter (destination start, source start, width, height or fill colour). Two "go" words start work: one paints the destination rectangle with a solid colour, and the other copies a source rectangle of the same size onto the destination. The stride between rows comes from a configuration input that gives the line length in pixels.

The engine reaches the frame memory through a plain request port with byte addresses and halfword data. Reads return data one cycle after the request. A fill writes one pixel per cycle. A copy reads a pixel and then writes it, so each pixel takes two cycles. Pixels are visited row by row, left to right and top to bottom. While an operation runs, the block reports busy and refuses new commands. When the operation ends, it gives a one-cycle completion pulse, plus an interrupt pulse if the go word asked for one.

Top module: `rect_blitter`

## Requirements
- R1: The opcode is in command bits 31:24. Any opcode other than 0x0B, 0x0C, 0x0D, 0x0E, 0x0F, 0x21 and 0x23 is accepted and has no effect: it does not change a parameter, start an operation or cause a memory access.
- R2: Opcode 0x0C loads the destination start address and opcode 0x0D loads the source start address. Each takes operand bits 23:1 and forces bit 0 to zero, so every memory address issued is even.
- R3: Opcode 0x0E loads the width minus one and opcode 0x0F loads the height minus one. Each is taken from operand bits 9:0, and the higher operand bits are ignored.
- R4: Opcode 0x0B loads the fill colour from operand bits 15:0. Bits 23:16 are ignored.
- R5: Opcode 0x23 writes the fill colour to (w+1)*(h+1) pixels, one per cycle, in row-major order. Pixel (x,y) is at byte address dst + (y*line_pix_i + x)*2. No other address is written.
- R6: Opcode 0x21 copies the pixel at src + (y*line_pix_i + x)*2 to dst + (y*line_pix_i + x)*2 for every pixel of the rectangle. Each pixel is a read cycle followed by a write cycle of the returned data.
- R7: busy_o is high from the cycle after a go word is accepted until the last memory access. That is N cycles for a fill and 2N cycles for a copy, where N is the pixel count. cmd_ready_o is low while busy_o is high.
- R8: done_o pulses for exactly one cycle in the cycle right after the last write. irq_o pulses in that same cycle only when bit 1 of the go word was 1.
- R9: Loaded parameters persist across operations until they are reloaded.
- R10: While reset is asserted, busy_o, done_o, irq_o and mem_req_o are low and cmd_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_pix_i | input | 11 | Line length in pixels (row stride) |
| cmd_valid_i | input | 1 | Command word present |
| cmd_word_i | input | 32 | Command word: opcode in 31:24, operand below |
| cmd_ready_o | output | 1 | Command accepted this cycle when valid |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 24 | Byte address, always even |
| mem_wdata_o | output | 16 | Write pixel |
| mem_rdata_i | input | 16 | Read pixel, valid the cycle after a read request |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| irq_o | output | 1 | Completion pulse gated by the go word's interrupt bit |

## Verification
If a go word is accepted at clock edge E, busy_o is high at the falling edges E+1 through E+N for a fill, or through E+2N for a copy. At the following falling edge busy_o is low and done_o is high, and at the falling edge after that done_o is low again. The bench drives the command port and samples every output at falling edges. It counts falling edges while busy_o is high and compares that count with N or 2N. It reads done_o and irq_o exactly when busy_o first drops. After each operation, the bench compares the entire behavioural memory with a shadow copy that it updates from the requirements.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam logic [7:0] OP_COLOUR  = 8'h0B;
  localparam logic [7:0] OP_DST     = 8'h0C;
  localparam logic [7:0] OP_SRC     = 8'h0D;
  localparam logic [7:0] OP_WIDTH   = 8'h0E;
  localparam logic [7:0] OP_HEIGHT  = 8'h0F;
  localparam logic [7:0] OP_GO_COPY = 8'h21;
  localparam logic [7:0] OP_GO_FILL = 8'h23;

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_RD, ST_WR} blit_st_e;
endpackage

// File: rtl/blit_params.sv
module blit_params
  import blit_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DIM_W  = 10,
  parameter int PIX_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [31:0]       word_i,
  output logic [ADDR_W-1:0] dst_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [DIM_W-1:0]  wid_o,
  output logic [DIM_W-1:0]  hgt_o,
  output logic [PIX_W-1:0]  col_o,
  output logic              go_fill_o,
  output logic              go_copy_o,
  output logic              irq_req_o
);
  logic [7:0] op;
  assign op = word_i[31:24];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_o <= '0;
      src_o <= '0;
      wid_o <= '0;
      hgt_o <= '0;
      col_o <= '0;
    end else if (wr_i) begin
      case (op)
        OP_DST:    dst_o <= {word_i[ADDR_W-1:1], 1'b0};
        OP_SRC:    src_o <= {word_i[ADDR_W-1:1], 1'b0};
        OP_WIDTH:  wid_o <= word_i[DIM_W-1:0];
        OP_HEIGHT: hgt_o <= word_i[DIM_W-1:0];
        OP_COLOUR: col_o <= word_i[PIX_W-1:0];
        default: ;
      endcase
    end
  end

  assign go_fill_o = wr_i && (op == OP_GO_FILL);
  assign go_copy_o = wr_i && (op == OP_GO_COPY);
  assign irq_req_o = word_i[1];

  AST_ADDR_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dst_o[0] && !src_o[0]); // R2
endmodule

// File: rtl/blit_walker.sv
module blit_walker #(
  parameter int ADDR_W = 24,
  parameter int DIM_W  = 10,
  parameter int LINE_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] dst_base_i,
  input  logic [ADDR_W-1:0] src_base_i,
  input  logic [DIM_W-1:0]  wid_i,
  input  logic [DIM_W-1:0]  hgt_i,
  input  logic [LINE_W-1:0] line_i,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic              last_o
);
  logic [DIM_W-1:0]  x_q, y_q;
  logic [ADDR_W-1:0] row_dst_q, row_src_q, stride, x_off;
  logic              row_end;

  assign stride  = ADDR_W'({line_i, 1'b0});
  assign x_off   = ADDR_W'({x_q, 1'b0});
  assign row_end = (x_q == wid_i);
  assign last_o  = row_end && (y_q == hgt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q       <= '0;
      y_q       <= '0;
      row_dst_q <= '0;
      row_src_q <= '0;
    end else if (start_i) begin
      x_q       <= '0;
      y_q       <= '0;
      row_dst_q <= dst_base_i;
      row_src_q <= src_base_i;
    end else if (step_i) begin
      if (row_end) begin
        x_q       <= '0;
        y_q       <= y_q + 1'b1;
        row_dst_q <= row_dst_q + stride;
        row_src_q <= row_src_q + stride;
      end else begin
        x_q <= x_q + 1'b1;
      end
    end
  end

  assign dst_addr_o = row_dst_q + x_off;
  assign src_addr_o = row_src_q + x_off;

  AST_X_IN_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !last_o) |=> (x_q <= wid_i)); // R5
endmodule

// File: rtl/rect_blitter.sv
module rect_blitter
  import blit_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DIM_W  = 10,
  parameter int PIX_W  = 16,
  parameter int LINE_W = DIM_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] line_pix_i,
  input  logic              cmd_valid_i,
  input  logic [31:0]       cmd_word_i,
  output logic              cmd_ready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [PIX_W-1:0]  mem_wdata_o,
  input  logic [PIX_W-1:0]  mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_o
);
  blit_st_e          st_q, st_d;
  logic              accept, go_fill, go_copy, irq_req, irq_en_q;
  logic              step, last, finish;
  logic [ADDR_W-1:0] dst_base, src_base, dst_addr, src_addr;
  logic [DIM_W-1:0]  wid, hgt;
  logic [PIX_W-1:0]  colour;

  assign cmd_ready_o = (st_q == ST_IDLE);
  assign accept      = cmd_valid_i && cmd_ready_o;

  blit_params #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .PIX_W(PIX_W)) u_params (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (accept),
    .word_i    (cmd_word_i),
    .dst_o     (dst_base),
    .src_o     (src_base),
    .wid_o     (wid),
    .hgt_o     (hgt),
    .col_o     (colour),
    .go_fill_o (go_fill),
    .go_copy_o (go_copy),
    .irq_req_o (irq_req)
  );

  blit_walker #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .LINE_W(LINE_W)) u_walker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (go_fill || go_copy),
    .step_i     (step),
    .dst_base_i (dst_base),
    .src_base_i (src_base),
    .wid_i      (wid),
    .hgt_i      (hgt),
    .line_i     (line_pix_i),
    .dst_addr_o (dst_addr),
    .src_addr_o (src_addr),
    .last_o     (last)
  );

  assign step   = (st_q == ST_FILL) || (st_q == ST_WR);
  assign finish = step && last;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (go_fill) st_d = ST_FILL;
               else if (go_copy) st_d = ST_RD;
      ST_FILL: if (last) st_d = ST_IDLE;
      ST_RD:   st_d = ST_WR;
      ST_WR:   st_d = last ? ST_IDLE : ST_RD;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      irq_en_q <= 1'b0;
      done_o   <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_o <= finish;
      irq_o  <= finish && irq_en_q;
      if (go_fill || go_copy) irq_en_q <= irq_req;
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign mem_req_o   = busy_o;
  assign mem_we_o    = step;
  assign mem_addr_o  = (st_q == ST_RD) ? src_addr : dst_addr;
  assign mem_wdata_o = (st_q == ST_FILL) ? colour : mem_rdata_i;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_IRQ_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done_o); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R7
  AST_WR_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WR) |-> $past(mem_req_o && !mem_we_o)); // R6
  AST_STALL_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cmd_valid_i)); // R7
endmodule

// File: tb/rect_blitter_tb.sv
module rect_blitter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_N = 4096;

  logic        clk = 0, rst_ni = 0;
  logic [10:0] line_pix = 11'd16;
  logic        cmd_valid = 0;
  logic [31:0] cmd_word = '0;
  logic        cmd_ready, mem_req, mem_we, busy, done, irq;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  logic [15:0] mem     [0:MEM_N-1];
  logic [15:0] exp_mem [0:MEM_N-1];
  int checks = 0, errors = 0, cyc_count = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rect_blitter u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .line_pix_i(line_pix),
    .cmd_valid_i(cmd_valid), .cmd_word_i(cmd_word), .cmd_ready_o(cmd_ready),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .done_o(done), .irq_o(irq)
  );

  always @(posedge clk) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_N; i++) mem[i] <= 16'(i) ^ 16'h5A5A;
      mem_rdata <= '0;
    end else if (mem_req) begin
      if (mem_we) mem[mem_addr[12:1]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[12:1]];
    end
  end

  always @(posedge clk) begin
    cyc_count <= cyc_count + 1;
    if (cyc_count > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // called at the negedge right after the go edge
  task automatic wait_op(output int cyc, output logic d, output logic q, output logic rdy_busy);
    cyc = 0;
    rdy_busy = cmd_ready;
    while (busy && cyc < 5000) begin
      cyc++;
      @(negedge clk);
    end
    d = done;
    q = irq;
  endtask

  task automatic chk_mem(input string req);
    int bad = -1;
    for (int i = 0; i < MEM_N; i++)
      if (bad < 0 && mem[i] !== exp_mem[i]) bad = i;
    if (bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, mem[bad], exp_mem[bad]);
  endtask

  task automatic exp_fill(input int dst, input int w, input int h, input int col);
    for (int y = 0; y <= h; y++)
      for (int x = 0; x <= w; x++)
        exp_mem[((dst & ~1) / 2 + y * int'(line_pix) + x) % MEM_N] = 16'(col);
  endtask

  task automatic exp_copy(input int src, input int dst, input int w, input int h);
    for (int y = 0; y <= h; y++)
      for (int x = 0; x <= w; x++)
        exp_mem[(dst / 2 + y * int'(line_pix) + x) % MEM_N] =
          exp_mem[(src / 2 + y * int'(line_pix) + x) % MEM_N];
  endtask

  task automatic t_reset;
    chk(!busy && !done && !irq && !mem_req, "R10 outputs idle in reset", {busy, done, irq, mem_req}, 0);
    chk(cmd_ready, "R10 ready in reset", cmd_ready, 1);
  endtask

  task automatic t_fill;
    int c; logic d, q, r;
    send(32'h0C00_0104); send(32'h0E00_0002); send(32'h0F00_0001);
    send(32'h0B00_BEEF); send(32'h2300_0003);
    wait_op(c, d, q, r);
    chk(!r, "R7 ready low while busy", r, 0);
    chk(c == 6, "R7 fill busy cycles", c, 6);
    chk(d, "R8 done at fill end", d, 1);
    chk(q, "R8 irq with bit1 set", q, 1);
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);
    exp_fill(32'h104, 2, 1, 16'hBEEF);
    chk_mem("R5 fill contents");
  endtask

  task automatic t_copy;
    int c; logic d, q, r;
    line_pix = 11'd32;
    send(32'h0D00_0400); send(32'h0C00_0800);
    send(32'h0E00_0001); send(32'h0F00_0002);
    send(32'h2100_0001);
    wait_op(c, d, q, r);
    chk(c == 12, "R6 copy busy cycles 2N", c, 12);
    chk(d && !q, "R8 done without irq when bit1 clear", {d, q}, 2);
    exp_copy(32'h400, 32'h800, 1, 2);
    chk_mem("R6 copy contents");
    line_pix = 11'd16;
  endtask

  task automatic t_odd_single;
    int c; logic d, q, r;
    send(32'h0C00_0601); send(32'h0E00_0000); send(32'h0F00_0000);
    send(32'h0BFF_1234); send(32'h2300_0000);
    wait_op(c, d, q, r);
    chk(c == 1, "R5 single pixel busy", c, 1);
    exp_fill(32'h600, 0, 0, 16'h1234);
    chk_mem("R2 R4 bit0 dropped, colour masked");
  endtask

  task automatic t_dim_mask;
    int c; logic d, q, r;
    send(32'h0C00_0A00); send(32'h0E00_FC01); send(32'h0F00_0400);
    send(32'h0B00_0777); send(32'h2300_0000);
    wait_op(c, d, q, r);
    chk(c == 2, "R3 width/height masked to 10 bits", c, 2);
    exp_fill(32'hA00, 1, 0, 16'h0777);
    chk_mem("R3 masked fill contents");
  endtask

  task automatic t_reserved;
    int c; logic d, q, r;
    send(32'h2200_0003); send(32'h0A00_0055); send(32'h2400_0001); send(32'h0000_0C00);
    repeat (3) begin
      @(negedge clk);
      chk(!busy && !mem_req && cmd_ready, "R1 reserved opcode no start", {busy, mem_req}, 0);
    end
    chk_mem("R1 reserved opcode no write");
    send(32'h0B00_00AA); send(32'h2300_0000);
    wait_op(c, d, q, r);
    chk(c == 2, "R9 previous dims kept", c, 2);
    exp_fill(32'hA00, 1, 0, 16'h00AA);
    chk_mem("R9 R1 previous dest kept");
  endtask

  initial begin
    for (int i = 0; i < MEM_N; i++) exp_mem[i] = 16'(i) ^ 16'h5A5A;
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1'b1;
    t_fill;
    t_copy;
    t_odd_single;
    t_dim_mask;
    t_reserved;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule